// File: doc/BRIEF.md
# Four-Channel DMA Register Window and Step Arbiter

This block holds four memory-to-memory transfer channels behind a small register window in the I/O page. Software programs each channel's source address, destination address, unit count and control word with 16-bit or 32-bit accesses; the block decodes every access to the right channel register and returns the only readable one, the control word. A channel that is switched on with immediate start timing becomes a candidate for the shared bus.

Each cycle in which the bus is free, a fixed-priority arbiter picks the lowest-numbered candidate and presents one transfer unit (source, destination, width, channel number) to the bus. The grant stays put until the bus reports the unit done, so a more urgent channel can only take over between units. While any candidate exists, the processor is told to stall, whatever else it was about to do. When a channel moves its last unit it switches itself off and, if asked to, raises a one-cycle interrupt pulse on its own bit.

Top module: `dma4_hub`

## Requirements
- R1: Channel n (0..3) owns the 12 bytes at offset 0xB0+12n: source at +0, destination at +4, count in the low half at +8, control in the high half at +10. 32-bit accesses must be word aligned and 16-bit accesses halfword aligned; a misaligned access writes nothing.
- R2: A 32-bit read at +8 returns the control word in bits 31:16 and zero in bits 15:0; a 16-bit read at +10 returns the control word in bits 15:0. Read data appears on the cycle after the read strobe.
- R3: Reads of source, destination or count, and misaligned reads, return zero.
- R4: Control bits: 15 on, 14 interrupt enable, 13:12 start timing, 10 unit width (1 = 32-bit, address step 4; 0 = 16-bit, step 2), 8:7 source adjust, 6:5 destination adjust; adjust code 0 increments, 1 decrements, 2 holds, 3 increments.
- R5: A write that turns bit 15 from 0 to 1 loads the working addresses and count from the programmed values; count 0 means 2^W units. Channel 0 source keeps 27 address bits, other sources 28; channel 3 destination keeps 28, other destinations 27; channel 3 count is 16 bits, the others 14.
- R6: A channel is a candidate when bit 15 is 1 and timing is 0; the free bus is granted to the lowest-numbered candidate, shown on bus_req_o with its addresses, width and number.
- R7: A grant holds, with unchanged outputs, until bus_done_i; only then may another channel win.
- R8: After its last unit a channel clears bit 15 and, when bit 14 is set, pulses irq_o bit n for one cycle.
- R9: cpu_stall_o is high in every cycle that any candidate exists.
- R10: A channel that is on with non-zero timing raises neither bus_req_o nor cpu_stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe |
| reg_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| reg_addr_i | input | 8 | byte offset within the I/O page |
| reg_wdata_i | input | 32 | write data (16-bit writes use bits 15:0) |
| reg_rdata_o | output | 32 | registered read data |
| bus_req_o | output | 1 | a unit transfer is requested |
| bus_chan_o | output | 2 | channel owning the request |
| bus_src_o | output | 32 | source address of the unit |
| bus_dst_o | output | 32 | destination address of the unit |
| bus_wide_o | output | 1 | 1 = 32-bit unit |
| bus_done_i | input | 1 | the requested unit has completed |
| cpu_stall_o | output | 1 | processor must do nothing this cycle |
| irq_o | output | 4 | per-channel completion pulse, bit n for channel n |

## Verification
The bench builds the block with its default parameters: four channels, 14-bit counts on channels 0 to 2 and a 16-bit count on channel 3. With 14-bit counts the zero-means-full case of 16384 units is short enough to run to its end, and four channels leave room to sweep every source adjust, destination adjust and width combination on each channel with addresses computed arithmetically. The masks of channel 0 and channel 3 are exercised with all-ones addresses, and priority with a held grant is shown by enabling a lower-numbered channel while a higher-numbered one waits for its bus.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int ADDR_W = 32;
  localparam int HALVES = 6;
  localparam int CTL_W  = 16;

  localparam int B_ON   = 15;
  localparam int B_IRQ  = 14;
  localparam int B_TMH  = 13;
  localparam int B_TML  = 12;
  localparam int B_WIDE = 10;
  localparam int B_SAH  = 8;
  localparam int B_SAL  = 7;
  localparam int B_DAH  = 6;
  localparam int B_DAL  = 5;

  typedef enum logic [1:0] {
    ADJ_UP   = 2'd0,
    ADJ_DOWN = 2'd1,
    ADJ_HOLD = 2'd2,
    ADJ_UP2  = 2'd3
  } adj_e;

  function automatic logic [ADDR_W-1:0] adj_addr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic wide);
    logic [ADDR_W-1:0] d;
    d = wide ? ADDR_W'(4) : ADDR_W'(2);
    case (adj_e'(mode))
      ADJ_DOWN: adj_addr = a - d;
      ADJ_HOLD: adj_addr = a;
      default:  adj_addr = a + d;
    endcase
  endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int                CW       = 14,
  parameter logic [ADDR_W-1:0] SRC_MASK = 32'h07FF_FFFF,
  parameter logic [ADDR_W-1:0] DST_MASK = 32'h07FF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALVES-1:0] hw_we,
  input  logic [31:0]       wd,
  input  logic              step_i,
  output logic              elig_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              wide_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              irq_o
);
  localparam logic [CW:0] FULL = (CW+1)'(1) << CW;

  logic [ADDR_W-1:0] src_q, dst_q, src_nx, dst_nx;
  logic [CW-1:0]     cnt_q, cnt_nx;
  logic [CTL_W-1:0]  ctl_q, ctl_nx;
  logic [ADDR_W-1:0] cur_src, cur_dst;
  logic [CW:0]       cur_cnt;
  logic              irq_q;

  always_comb begin
    src_nx = src_q;
    dst_nx = dst_q;
    if (hw_we[0]) src_nx[15:0]  = wd[15:0];
    if (hw_we[1]) src_nx[31:16] = wd[31:16];
    if (hw_we[2]) dst_nx[15:0]  = wd[15:0];
    if (hw_we[3]) dst_nx[31:16] = wd[31:16];
    cnt_nx = hw_we[4] ? wd[CW-1:0] : cnt_q;
    ctl_nx = hw_we[5] ? wd[31:16]  : ctl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      irq_q   <= 1'b0;
    end else begin
      src_q <= src_nx & SRC_MASK;
      dst_q <= dst_nx & DST_MASK;
      cnt_q <= cnt_nx;
      irq_q <= 1'b0;
      if (step_i && ctl_q[B_ON]) begin
        cur_src <= adj_addr(cur_src, ctl_q[B_SAH:B_SAL], ctl_q[B_WIDE]) & SRC_MASK;
        cur_dst <= adj_addr(cur_dst, ctl_q[B_DAH:B_DAL], ctl_q[B_WIDE]) & DST_MASK;
        cur_cnt <= cur_cnt - 1'b1;
        if (cur_cnt == (CW+1)'(1)) begin
          ctl_q[B_ON] <= 1'b0;
          irq_q       <= ctl_q[B_IRQ];
        end
      end
      if (hw_we[5]) begin
        ctl_q <= ctl_nx;
        if (!ctl_q[B_ON] && ctl_nx[B_ON]) begin
          cur_src <= src_nx & SRC_MASK;
          cur_dst <= dst_nx & DST_MASK;
          cur_cnt <= (cnt_nx == '0) ? FULL : {1'b0, cnt_nx};
        end
      end
    end
  end

  assign elig_o = ctl_q[B_ON] && (ctl_q[B_TMH:B_TML] == 2'b00);
  assign src_o  = cur_src;
  assign dst_o  = cur_dst;
  assign wide_o = ctl_q[B_WIDE];
  assign ctl_o  = ctl_q;
  assign irq_o  = irq_q;

  // R8
  irq_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(step_i));

  // R5
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[B_ON]) |-> (cur_cnt != '0));
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] elig_i,
  input  logic           done_i,
  output logic           busy_o,
  output logic [IW-1:0]  gnt_o,
  output logic [NCH-1:0] step_o
);
  logic          busy_q;
  logic [IW-1:0] gnt_q;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (elig_i[i]) begin
        pick  = IW'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q <= 1'b1;
        gnt_q  <= pick;
      end
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    step_o = '0;
    if (busy_q && done_i) step_o[gnt_q] = 1'b1;
  end

  assign busy_o = busy_q;
  assign gnt_o  = gnt_q;

  function automatic logic [NCH-1:0] below(input logic [IW-1:0] g);
    below = '0;
    for (int i = 0; i < NCH; i++) if (i < int'(g)) below[i] = 1'b1;
  endfunction

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_i) |=> (busy_q && $stable(gnt_q)));

  // R6
  grant_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && (|elig_i)) |=> busy_q);

  // R6
  prio_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (($past(elig_i) & below(gnt_q)) == '0));
endmodule

// File: rtl/dma4_regif.sv
module dma4_regif
  import dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int REG_AW = 8,
  parameter int BASE   = 'hB0,
  parameter int BLK    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wide_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CTL_W-1:0]  ctl_i [NCH],
  output logic [HALVES-1:0] hw_we [NCH],
  output logic [31:0]       wd_o,
  output logic [31:0]       rdata_o
);
  logic [31:0] rd_val;
  logic        wo_hit;
  logic [31:0] rdata_q;

  assign wd_o = wide_i ? wdata_i : {wdata_i[15:0], wdata_i[15:0]};

  always_comb begin
    logic [REG_AW-1:0] rel;
    logic [2:0]        k;
    logic              hit;
    rd_val = '0;
    wo_hit = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      hw_we[c] = '0;
      rel = addr_i - REG_AW'(BASE + BLK*c);
      hit = (addr_i >= REG_AW'(BASE + BLK*c)) && (rel < REG_AW'(BLK));
      k   = rel[3:1];
      if (hit) begin
        if (wide_i) begin
          if (rel[1:0] == 2'b00) begin
            if (wr_i) begin
              hw_we[c][k]             = 1'b1;
              hw_we[c][3'(k + 3'd1)]  = 1'b1;
            end
            if (rel == REG_AW'(8)) rd_val = {ctl_i[c], 16'h0000};
            else                   wo_hit = 1'b1;
          end
        end else if (!rel[0]) begin
          if (wr_i) hw_we[c][k] = 1'b1;
          if (rel == REG_AW'(10)) rd_val = {16'h0000, ctl_i[c]};
          else                    wo_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R3
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wo_hit) |=> (rdata_o == '0));
endmodule

// File: rtl/dma4_hub.sv
module dma4_hub
  import dma4_pkg::*;
#(
  parameter int                NCH        = 4,
  parameter int                REG_AW     = 8,
  parameter int                BASE       = 'hB0,
  parameter int                BLK        = 12,
  parameter int                CNT_W_LO   = 14,
  parameter int                CNT_W_HI   = 16,
  parameter logic [ADDR_W-1:0] MASK_NARROW = 32'h07FF_FFFF,
  parameter logic [ADDR_W-1:0] MASK_WIDE   = 32'h0FFF_FFFF,
  localparam int               IW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wide_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              bus_req_o,
  output logic [IW-1:0]     bus_chan_o,
  output logic [ADDR_W-1:0] bus_src_o,
  output logic [ADDR_W-1:0] bus_dst_o,
  output logic              bus_wide_o,
  input  logic              bus_done_i,
  output logic              cpu_stall_o,
  output logic [NCH-1:0]    irq_o
);
  logic [HALVES-1:0] hw_we  [NCH];
  logic [31:0]       wd;
  logic [CTL_W-1:0]  ch_ctl [NCH];
  logic [ADDR_W-1:0] ch_src [NCH];
  logic [ADDR_W-1:0] ch_dst [NCH];
  logic [NCH-1:0]    ch_wide;
  logic [NCH-1:0]    elig;
  logic [NCH-1:0]    step;
  logic              busy;
  logic [IW-1:0]     gnt;

  dma4_regif #(.NCH(NCH), .REG_AW(REG_AW), .BASE(BASE), .BLK(BLK)) u_regif (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .rd_i(reg_rd_i), .wide_i(reg_wide_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .ctl_i(ch_ctl),
    .hw_we(hw_we), .wd_o(wd), .rdata_o(reg_rdata_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int                CW = (i == NCH-1) ? CNT_W_HI : CNT_W_LO;
    localparam logic [ADDR_W-1:0] SM = (i == 0)     ? MASK_NARROW : MASK_WIDE;
    localparam logic [ADDR_W-1:0] DM = (i == NCH-1) ? MASK_WIDE   : MASK_NARROW;
    dma4_chan #(.CW(CW), .SRC_MASK(SM), .DST_MASK(DM)) u_chan (
      .clk(clk), .rst(rst), .hw_we(hw_we[i]), .wd(wd), .step_i(step[i]),
      .elig_o(elig[i]), .src_o(ch_src[i]), .dst_o(ch_dst[i]),
      .wide_o(ch_wide[i]), .ctl_o(ch_ctl[i]), .irq_o(irq_o[i])
    );
  end

  dma4_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst(rst), .elig_i(elig), .done_i(bus_done_i),
    .busy_o(busy), .gnt_o(gnt), .step_o(step)
  );

  assign bus_req_o   = busy;
  assign bus_chan_o  = gnt;
  assign bus_src_o   = ch_src[gnt];
  assign bus_dst_o   = ch_dst[gnt];
  assign bus_wide_o  = ch_wide[gnt];
  assign cpu_stall_o = |elig;

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_o));

  // R9
  stall_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_o) |-> $past(cpu_stall_o));
endmodule

// File: tb/dma4_hub_bench.sv
module dma4_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_wide, bus_done = 1'b0, cpu_stall;
  logic [1:0]  bus_chan;
  logic [31:0] bus_src, bus_dst;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma4_hub u_dma4_hub (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wide_i(reg_wide),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_chan_o(bus_chan), .bus_src_o(bus_src), .bus_dst_o(bus_dst),
    .bus_wide_o(bus_wide), .bus_done_i(bus_done), .cpu_stall_o(cpu_stall), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] cb(input int n);
    return 8'(8'hB0 + 12*n);
  endfunction

  task automatic wr(input logic wide, input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic wide, input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_wide = wide; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_req(input string tag);
    int t = 0;
    while (!bus_req && t < 50) begin @(negedge clk); t++; end
    check({tag, " req"}, 32'(bus_req), 32'd1);
  endtask

  task automatic do_step(input string tag, input int ch, input logic [31:0] s,
                         input logic [31:0] d, input logic w);
    wait_req(tag);
    check({tag, " chan"}, 32'(bus_chan), 32'(ch));
    check({tag, " src"},  bus_src, s);
    check({tag, " dst"},  bus_dst, d);
    check({tag, " wide"}, 32'(bus_wide), 32'(w));
    check({tag, " stall"}, 32'(cpu_stall), 32'd1);
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got %h exp %h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset stall", 32'(cpu_stall), 0);
    check("R6 reset req", 32'(bus_req), 0);
    check("R8 reset irq", 32'(irq), 0);
    check("R2 reset rdata", reg_rdata, 0);

    // register window sweep, all channels idle
    for (int n = 0; n < 4; n++) begin
      logic [15:0] c1, c2;
      c1 = 16'h4000 | 16'(n << 5) | 16'h0400;
      c2 = 16'h0200 | 16'(n);
      wr(1, cb(n),     32'hFFFF_FFFF);
      wr(1, cb(n) + 4, 32'hFFFF_FFFF);
      wr(1, cb(n) + 8, {c1, 16'h1234});
      rd(1, cb(n),     v); check("R3 src read zero", v, 0);
      rd(1, cb(n) + 4, v); check("R3 dst read zero", v, 0);
      rd(0, cb(n) + 8, v); check("R3 count read zero", v, 0);
      rd(1, cb(n) + 8, v); check("R2 ctl 32-bit read", v, {c1, 16'h0});
      rd(0, cb(n) + 10, v); check("R2 ctl 16-bit read", v, {16'h0, c1});
      wr(0, cb(n) + 10, {16'h0, c2});
      rd(1, cb(n) + 8, v); check("R1 16-bit ctl write", v, {c2, 16'h0});
      wr(1, cb(n) + 10, 32'h8000_8000);
      rd(0, cb(n) + 10, v); check("R1 misaligned write ignored", v, {16'h0, c2});
      rd(1, cb(n) + 2, v); check("R3 misaligned read zero", v, 0);
      check("R9 idle stall", 32'(cpu_stall), 0);
    end
    for (int n = 0; n < 4; n++) wr(0, cb(n) + 10, 0);

    // R10 non-zero timing
    wr(0, cb(1) + 10, 32'h9000);
    repeat (5) @(negedge clk);
    check("R10 no req", 32'(bus_req), 0);
    check("R10 no stall", 32'(cpu_stall), 0);
    rd(0, cb(1) + 10, v); check("R10 ctl kept", v, 32'h9000);
    wr(0, cb(1) + 10, 0);

    // R5 masks, channel 0 and 3
    wr(1, cb(0),     32'hFFFF_FFFF);
    wr(1, cb(0) + 4, 32'hFFFF_FFFF);
    wr(1, cb(0) + 8, 32'hC500_0002);
    do_step("R5 ch0 mask u0", 0, 32'h07FF_FFFF, 32'h07FF_FFFF, 1);
    check("R8 no irq mid", 32'(irq), 0);
    do_step("R5 ch0 mask u1", 0, 32'h07FF_FFFF, 32'h0000_0003, 1);
    check("R8 ch0 irq", 32'(irq), 32'h1);
    check("R8 stall drop", 32'(cpu_stall), 0);
    rd(0, cb(0) + 10, v); check("R8 on cleared", v, 32'h4500);
    wr(1, cb(3),     32'hFFFF_FFFF);
    wr(0, cb(3) + 4, 32'hFFFF);
    wr(0, cb(3) + 6, 32'hFFFF);
    wr(1, cb(3) + 8, 32'h80A0_0002);
    do_step("R5 ch3 mask u0", 3, 32'h0FFF_FFFF, 32'h0FFF_FFFF, 0);
    do_step("R4 ch3 dec u1", 3, 32'h0FFF_FFFD, 32'h0FFF_FFFD, 0);
    check("R8 no irq when disabled", 32'(irq), 0);

    // R4 adjust and width sweep
    for (int n = 0; n < 4; n++)
      for (int sa = 0; sa < 4; sa++)
        for (int da = 0; da < 4; da++)
          for (int w = 0; w < 2; w++) begin
            logic [31:0] s, d, st;
            logic [15:0] c;
            st = (w != 0) ? 32'd4 : 32'd2;
            s = 32'h1000; d = 32'h2000;
            c = 16'hC000 | 16'(w << 10) | 16'(sa << 7) | 16'(da << 5);
            wr(1, cb(n),     s);
            wr(1, cb(n) + 4, d);
            wr(1, cb(n) + 8, {c, 16'd3});
            for (int k = 0; k < 3; k++) begin
              do_step("R4 sweep", n, s, d, w[0]);
              s = (sa == 1) ? s - st : (sa == 2) ? s : s + st;
              d = (da == 1) ? d - st : (da == 2) ? d : d + st;
            end
            check("R8 sweep irq", 32'(irq), 32'(1 << n));
            rd(1, cb(n) + 8, v); check("R8 sweep off", v, {c & 16'h7FFF, 16'h0});
          end

    // R6 / R7 priority with held grant
    wr(1, cb(3),     32'h3000);
    wr(1, cb(3) + 4, 32'h3100);
    wr(1, cb(3) + 8, 32'h8000_0003);
    wait_req("R6 ch3 first");
    check("R6 ch3 granted", 32'(bus_chan), 3);
    wr(1, cb(1),     32'h1000);
    wr(1, cb(1) + 4, 32'h1100);
    wr(1, cb(1) + 8, 32'h8000_0002);
    repeat (3) @(negedge clk);
    check("R7 grant held chan", 32'(bus_chan), 3);
    check("R7 grant held src", bus_src, 32'h3000);
    check("R9 stall while waiting", 32'(cpu_stall), 1);
    do_step("R7 ch3 u0", 3, 32'h3000, 32'h3100, 0);
    do_step("R6 ch1 u0", 1, 32'h1000, 32'h1100, 0);
    do_step("R6 ch1 u1", 1, 32'h1002, 32'h1102, 0);
    do_step("R6 ch3 u1", 3, 32'h3002, 32'h3102, 0);
    do_step("R6 ch3 u2", 3, 32'h3004, 32'h3104, 0);
    check("R9 stall done", 32'(cpu_stall), 0);

    // R5 count zero means 2^14 units
    begin
      int early = 0;
      wr(1, cb(0),     32'h40);
      wr(1, cb(0) + 4, 32'h80);
      wr(1, cb(0) + 8, 32'hC140_0000);
      for (int k = 0; k < 16384; k++) begin
        while (!bus_req) @(negedge clk);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        if (k < 16383 && irq != 0) early++;
        if (k == 16383) check("R5 full count irq", 32'(irq), 1);
      end
      check("R5 no early irq", 32'(early), 0);
      check("R5 stall after full count", 32'(cpu_stall), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule